// File: doc/BRIEF.md
# RTC Interrupt Emulation Sequencer

This block stands in for the interrupt side of a legacy real-time clock when the real clock's interrupt line is taken by a free-running system timer. A single base strobe, raised whenever the timer counter passes the current deadline, drives three kinds of event: an update event when the seconds value moves, an alarm event when the time of day equals a stored alarm time, and a periodic event made by dividing the base strobe down to the requested rate. On each strobe the sequencer evaluates all three sources and, if any of them fired, raises a one-cycle interrupt together with a 16-bit flag word in the layout that a legacy clock driver decodes.

The sequencer also owns the timing of the base strobe. It picks the base rate (64 Hz, or the periodic rate when that is faster), turns it into a counter step, and schedules the next deadline by adding the step to the previous deadline. When a strobe arrives so late that this deadline is already behind the counter, a multi-cycle divider counts the lost strobes and the deadline jumps back into the future, crediting the periodic divider with the lost count. Clearing all three enables stops the strobe timer. Enabling any source from that state re-arms it from the current counter value.

The strobe input is a valid/ready pair: a strobe is held on `strb_valid` until it is taken on a cycle with `strb_ready` high. Ready is low while a strobe is being processed, for one cycle normally and for CNT_W+2 cycles when a catch-up division runs. A strobe offered while the timer is stopped is taken and discarded. The interrupt output is a plain pulse with no back-pressure. Rates are given as base-2 exponents and the counter runs at 2^SEC_LOG ticks per second, so every step and every division ratio is a power of two.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset `irq` is 0, `flags` is 0, `tmr_en` is 0 and `strb_ready` is 1.
- R2: `base_log` equals `per_log2` when `per_en` is 1 and `per_log2` is above 6, and equals 6 otherwise. `step` equals 2^(SEC_LOG - base_log).
- R3: On a clock edge where any enable is 1 and `tmr_en` is 0, `tmr_en` becomes 1 and `deadline` becomes `cnt_now + step`, using the values at that edge.
- R4: On an edge where all three enables are 0, `tmr_en` becomes 0. A strobe taken while `tmr_en` is 0 raises no interrupt and leaves `deadline` unchanged, and `strb_ready` stays 1.
- R5: A strobe taken while `tmr_en` is 1, with `cnt_now - (deadline + step)` zero or negative as a CNT_W-bit signed value, sets `deadline` to `deadline + step`. `strb_ready` is low for exactly one cycle, and any interrupt is a one-cycle pulse in the cycle where `strb_ready` returns high.
- R6: The update flag (bit 4) is set on a strobe where `upd_en` is 1 and `tod_sec` differs from the recorded seconds value. The recorded value (0 after reset) then takes `tod_sec`.
- R7: The alarm flag (bit 5) is set on a strobe where `alm_en` is 1 and `tod_hr`, `tod_min` and `tod_sec` equal `alm_hr`, `alm_min` and `alm_sec`.
- R8: With `per_en` at 1, each strobe increments a periodic count. When the count reaches 2^(base_log - per_log2), the periodic flag (bit 6) is set and the count returns to 0. The count is cleared when `per_en` rises and whenever `per_log2` changes.
- R9: When any of bits 4 to 6 is set, `irq` pulses and `flags` also carries the summary bit 7 and the value 1 in bits 15:8. When none is set, `irq` stays 0 and `flags` is 0.
- R10: If `d = cnt_now - (deadline + step)` is positive as a signed value, `deadline` becomes `deadline + step + (d/step + 2)*step` (modulo 2^CNT_W). `strb_ready` is low for CNT_W+2 cycles.
- R11: In the catch-up case of R10 with `per_en` at 1, the periodic count is increased by `d/step + 2` before the periodic event of that strobe is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_valid | input | 1 | Base strobe offered |
| strb_ready | output | 1 | Sequencer idle, strobe can be taken |
| cnt_now | input | CNT_W | Current timer counter value |
| tod_hr | input | TIME_W | Current hours |
| tod_min | input | TIME_W | Current minutes |
| tod_sec | input | TIME_W | Current seconds |
| upd_en | input | 1 | Update event enable |
| alm_en | input | 1 | Alarm event enable |
| per_en | input | 1 | Periodic event enable |
| alm_hr | input | TIME_W | Alarm hours |
| alm_min | input | TIME_W | Alarm minutes |
| alm_sec | input | TIME_W | Alarm seconds |
| per_log2 | input | 4 | Periodic rate exponent, 1 (2 Hz) to 13 (8192 Hz) |
| tmr_en | output | 1 | Strobe timer running |
| deadline | output | CNT_W | Counter value of the next strobe |
| step | output | CNT_W | Counter ticks per base strobe |
| base_log | output | 4 | Base strobe rate exponent |
| irq | output | 1 | Interrupt pulse |
| flags | output | 16 | Event flag word, valid with `irq` |

## Verification
The update and alarm sources share one strobe, so the bench moves the seconds value on every strobe while sweeping hours, minutes and seconds around the alarm time: on the matching strobe both bit 4 and bit 5 must appear in one flag word with a single summary bit and a count of 1. Catch-up and the periodic divider also meet in one strobe. The bench makes a strobe late by a chosen number of steps and checks that the periodic event lands on the strobe predicted by the credited count, and that the deadline is placed where the arithmetic model puts it. It also covers the edge where the lag is exactly zero (no catch-up) and the edge where it is one tick (a lost count of 2).

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int FLAG_W       = 16;
  localparam int FLG_UPD      = 4;
  localparam int FLG_ALM      = 5;
  localparam int FLG_PER      = 6;
  localparam int FLG_IRQ      = 7;
  localparam int CNT_LSB      = 8;
  localparam int EVT_COUNT    = 1;
  localparam int BASE_MIN_LOG = 6;
  localparam int RATE_W       = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_EMIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel
  import rtc_emu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SEC_LOG = 20
) (
  input  logic              per_en,
  input  logic [RATE_W-1:0] per_log2,
  output logic [RATE_W-1:0] base_log,
  output logic [CNT_W-1:0]  step,
  output logic [CNT_W-1:0]  ratio
);
  localparam logic [RATE_W-1:0] MIN_LOG = RATE_W'(BASE_MIN_LOG);
  localparam logic [5:0]        SEC_L6  = 6'(SEC_LOG);
  localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

  always_comb begin
    base_log = (per_en && (per_log2 > MIN_LOG)) ? per_log2 : MIN_LOG;
    step     = ONE << (SEC_L6 - {2'b00, base_log});
    if (per_log2 <= base_log)
      ratio = ONE << ({2'b00, base_log} - {2'b00, per_log2});
    else
      ratio = ONE;
  end
endmodule

// File: rtl/rtc_lost_div.sv
module rtc_lost_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    trial, diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = trial >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q <= dividend;
        rem_q <= '0;
        dvs_q <= divisor;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        if (fits) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

  // R10: the remainder handed back is always below the divisor
  p_rem_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dvs_q));
  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/rtc_evt_eval.sv
module rtc_evt_eval
  import rtc_emu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 8
) (
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [TIME_W-1:0] hr,
  input  logic [TIME_W-1:0] min,
  input  logic [TIME_W-1:0] sec,
  input  logic [TIME_W-1:0] alm_hr,
  input  logic [TIME_W-1:0] alm_min,
  input  logic [TIME_W-1:0] alm_sec,
  input  logic [TIME_W-1:0] last_sec,
  input  logic [CNT_W-1:0]  pcount,
  input  logic [CNT_W-1:0]  ratio,
  output logic              upd_hit,
  output logic              per_hit,
  output logic              fire,
  output logic [FLAG_W-1:0] word
);
  logic alm_hit;

  always_comb begin
    upd_hit = upd_en && (sec != last_sec);
    alm_hit = alm_en && (hr == alm_hr) && (min == alm_min) && (sec == alm_sec);
    per_hit = per_en && (({1'b0, pcount} + (CNT_W+1)'(1)) >= {1'b0, ratio});
    fire    = upd_hit || alm_hit || per_hit;
    word    = '0;
    if (fire) begin
      word[FLG_UPD] = upd_hit;
      word[FLG_ALM] = alm_hit;
      word[FLG_PER] = per_hit;
      word[FLG_IRQ] = 1'b1;
      word[FLAG_W-1:CNT_LSB] = (FLAG_W-CNT_LSB)'(EVT_COUNT);
    end
  end
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rtc_emu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TIME_W  = 8,
  parameter int SEC_LOG = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_valid,
  output logic              strb_ready,
  input  logic [CNT_W-1:0]  cnt_now,
  input  logic [TIME_W-1:0] tod_hr,
  input  logic [TIME_W-1:0] tod_min,
  input  logic [TIME_W-1:0] tod_sec,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [TIME_W-1:0] alm_hr,
  input  logic [TIME_W-1:0] alm_min,
  input  logic [TIME_W-1:0] alm_sec,
  input  logic [3:0]        per_log2,
  output logic              tmr_en,
  output logic [CNT_W-1:0]  deadline,
  output logic [CNT_W-1:0]  step,
  output logic [3:0]        base_log,
  output logic              irq,
  output logic [15:0]       flags
);
  seq_state_t        state;
  logic              tmr_en_q, pie_q, irq_q;
  logic [3:0]        rate_q;
  logic [CNT_W-1:0]  dl_q, step_l, cnt_l, pcount_q, ratio;
  logic [TIME_W-1:0] t_hr, t_min, t_sec, last_sec_q;
  logic [15:0]       flags_q;

  logic              any_en, accept, behind, pc_clear;
  logic [CNT_W-1:0]  nd, lag, div_quo, div_rem, ahead;
  logic [CNT_W:0]    credit;
  logic              div_done, upd_hit, per_hit, fire;
  logic [FLAG_W-1:0] word;

  rtc_rate_sel #(.CNT_W(CNT_W), .SEC_LOG(SEC_LOG)) u_rate (
    .per_en(per_en), .per_log2(per_log2),
    .base_log(base_log), .step(step), .ratio(ratio)
  );

  always_comb begin
    any_en   = upd_en || alm_en || per_en;
    accept   = strb_valid && (state == ST_IDLE) && tmr_en_q;
    nd       = dl_q + step;
    lag      = cnt_now - nd;
    behind   = !lag[CNT_W-1] && (lag != '0);
    pc_clear = (per_en && !pie_q) || (per_log2 != rate_q);
    credit   = {1'b0, pcount_q} + {1'b0, div_quo} + (CNT_W+1)'(2);
    ahead    = dl_q - cnt_l;
  end

  rtc_lost_div #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept && behind),
    .dividend(lag), .divisor(step),
    .done(div_done), .quotient(div_quo), .remainder(div_rem)
  );

  rtc_evt_eval #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_eval (
    .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en),
    .hr(t_hr), .min(t_min), .sec(t_sec),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
    .last_sec(last_sec_q), .pcount(pcount_q), .ratio(ratio),
    .upd_hit(upd_hit), .per_hit(per_hit), .fire(fire), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tmr_en_q   <= 1'b0;
      pie_q      <= 1'b0;
      rate_q     <= '0;
      irq_q      <= 1'b0;
      flags_q    <= '0;
      dl_q       <= '0;
      step_l     <= '0;
      cnt_l      <= '0;
      pcount_q   <= '0;
      t_hr       <= '0;
      t_min      <= '0;
      t_sec      <= '0;
      last_sec_q <= '0;
    end else begin
      pie_q    <= per_en;
      rate_q   <= per_log2;
      tmr_en_q <= any_en;
      irq_q    <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          t_hr   <= tod_hr;
          t_min  <= tod_min;
          t_sec  <= tod_sec;
          cnt_l  <= cnt_now;
          step_l <= step;
          if (behind) begin
            state <= ST_DIV;
          end else begin
            dl_q  <= nd;
            state <= ST_EMIT;
          end
        end
        ST_DIV: if (div_done) begin
          // deadline + step + (q+2)*step reduces to cnt - rem + 2*step
          dl_q <= cnt_l - div_rem + {step_l[CNT_W-2:0], 1'b0};
          if (per_en)
            pcount_q <= credit[CNT_W] ? '1 : credit[CNT_W-1:0];
          state <= ST_EMIT;
        end
        ST_EMIT: begin
          irq_q   <= fire;
          flags_q <= word;
          if (upd_hit) last_sec_q <= t_sec;
          if (per_en) pcount_q <= per_hit ? '0 : pcount_q + CNT_W'(1);
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (pc_clear) pcount_q <= '0;
      if (any_en && !tmr_en_q) dl_q <= cnt_now + step;
    end
  end

  assign strb_ready = (state == ST_IDLE);
  assign tmr_en     = tmr_en_q;
  assign deadline   = dl_q;
  assign irq        = irq_q;
  assign flags      = flags_q;

  // R2: the base rate never drops below 64 Hz and the step is a power of two
  p_base_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    base_log >= 4'(BASE_MIN_LOG));
  p_step_pow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step) == 1);
  // R3: arming from the all-off state starts from the live counter
  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en && !tmr_en_q) |=> (tmr_en_q && (dl_q == $past(cnt_now + step))));
  // R5: the interrupt never lasts more than one cycle
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R9: every interrupt carries a source flag, the summary bit and a count of one
  p_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (flags_q[FLG_IRQ] && (flags_q[15:8] == 8'd1) && (|flags_q[6:4])));
  // R10: after catch-up the deadline lies ahead of the counter seen at the strobe
  p_future_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DIV) && div_done && tmr_en_q && any_en) |=>
      (!ahead[CNT_W-1] && (ahead != '0)));
endmodule

// File: tb/test_rtc_irq_emu.sv
module test_rtc_irq_emu;
  localparam int W  = 16;
  localparam int SL = 14;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, strb_valid, strb_ready, upd_en, alm_en, per_en;
  logic [W-1:0]  cnt_now, deadline, step;
  logic [TW-1:0] tod_hr, tod_min, tod_sec, alm_hr, alm_min, alm_sec;
  logic [3:0]    per_log2, base_log;
  logic          tmr_en, irq;
  logic [15:0]   flags;

  rtc_irq_emu #(.CNT_W(W), .TIME_W(TW), .SEC_LOG(SL)) i_rtc_irq_emu (
    .clk(clk), .rst_n(rst_n), .strb_valid(strb_valid), .strb_ready(strb_ready),
    .cnt_now(cnt_now), .tod_hr(tod_hr), .tod_min(tod_min), .tod_sec(tod_sec),
    .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec), .per_log2(per_log2),
    .tmr_en(tmr_en), .deadline(deadline), .step(step), .base_log(base_log),
    .irq(irq), .flags(flags)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [W-1:0]  m_dl = '0;
  int            m_pc = 0;
  logic [TW-1:0] m_last = '0;
  bit            m_tmr = 0, m_pie = 0;
  logic [3:0]    m_rate = '0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int f_base(input bit p, input int r);
    return (p && r > 6) ? r : 6;
  endfunction

  function automatic int f_step(input bit p, input int r);
    return 1 << (SL - f_base(p, r));
  endfunction

  task automatic cfg(input bit u, input bit a, input bit p, input int r,
                     input logic [W-1:0] c);
    bit any;
    upd_en = u; alm_en = a; per_en = p; per_log2 = 4'(r); cnt_now = c;
    any = u | a | p;
    if ((p && !m_pie) || (4'(r) != m_rate)) m_pc = 0;
    if (any && !m_tmr) m_dl = c + W'(f_step(p, r));
    m_tmr = any; m_pie = p; m_rate = 4'(r);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic [W-1:0] c, input logic [TW-1:0] h,
                        input logic [TW-1:0] m, input logic [TW-1:0] s);
    int st, k, exp_k, rt;
    logic [W-1:0] nd, d;
    bit eu, ea, ep, fire;
    logic [15:0] ef;
    strb_valid = 1'b1; cnt_now = c; tod_hr = h; tod_min = m; tod_sec = s;
    @(posedge clk);
    #1 strb_valid = 1'b0;
    eu = 0; ea = 0; ep = 0; exp_k = 0;
    if (m_tmr) begin
      st = f_step(per_en, int'(per_log2));
      nd = m_dl + W'(st);
      d  = c - nd;
      if (!d[W-1] && d != '0) begin
        m_dl = nd + W'((int'(d) / st + 2) * st);
        if (per_en) m_pc = m_pc + int'(d) / st + 2;
        exp_k = W + 2;
      end else begin
        m_dl = nd;
        exp_k = 1;
      end
      eu = upd_en && (s != m_last);
      if (eu) m_last = s;
      ea = alm_en && h == alm_hr && m == alm_min && s == alm_sec;
      if (per_en) begin
        rt = 1 << (f_base(1, int'(per_log2)) - int'(per_log2));
        m_pc++;
        if (m_pc >= rt) begin ep = 1; m_pc = 0; end
      end
    end
    fire = eu | ea | ep;
    ef = fire ? (16'h0180 | (16'(eu) << 4) | (16'(ea) << 5) | (16'(ep) << 6)) : 16'h0;
    @(negedge clk);
    k = 0;
    while (!strb_ready && k < 100) begin @(negedge clk); k++; end
    chk(exp_k > 1 ? "R10 busy cycles" : (exp_k == 1 ? "R5 busy cycles" : "R4 ignored strobe"), k, exp_k);
    chk("R9 irq", irq, fire);
    chk("R9 flags (R6 R7 R8 R11)", flags & {16{fire}}, ef);
    chk(exp_k > 1 ? "R10 deadline" : "R5 deadline", deadline, m_dl);
    @(negedge clk);
    chk("R5 irq pulse width", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strb_valid = 1'b0; cnt_now = '0;
    tod_hr = '0; tod_min = '0; tod_sec = '0;
    upd_en = 1'b0; alm_en = 1'b0; per_en = 1'b0; per_log2 = '0;
    alm_hr = 8'd12; alm_min = 8'd34; alm_sec = 8'd56;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 flags", flags, 0);
    chk("R1 tmr_en", tmr_en, 0);
    chk("R1 strb_ready", strb_ready, 1);

    // R2: base rate and step over both periodic enable states and all rates
    for (int p = 0; p < 2; p++)
      for (int r = 1; r <= 13; r++) begin
        cfg(0, 0, p[0], r, 16'h0100);
        chk("R2 base_log", base_log, f_base(p[0], r));
        chk("R2 step", step, f_step(p[0], r));
      end

    // R4: all enables clear stops the timer, strobes are discarded
    cfg(0, 0, 0, 13, 16'h0);
    chk("R4 tmr_en", tmr_en, 0);
    strobe(16'h1234, 8'd1, 8'd2, 8'd3);

    // R3: re-arm from the live counter
    cfg(1, 0, 0, 0, 16'd1000);
    chk("R3 tmr_en", tmr_en, 1);
    chk("R3 deadline", deadline, 16'd1256);

    // R6: update events follow changes of the seconds value
    begin
      int secs[9] = '{0, 0, 1, 1, 2, 5, 5, 59, 0};
      foreach (secs[i]) strobe(m_dl, 8'd0, 8'd0, 8'(secs[i]));
    end

    // R7 with R6: alarm sweep around 12:34:56 with update in the same strobe
    cfg(1, 1, 0, 0, 16'h0);
    for (int h = 12; h <= 13; h++)
      for (int m = 34; m <= 35; m++)
        for (int s = 56; s <= 57; s++)
          strobe(m_dl, 8'(h), 8'(m), 8'(s));

    // R8: periodic division at every rate, counter cleared on rate change
    for (int r = 1; r <= 13; r++) begin
      int rt;
      cfg(0, 0, 1, r, 16'h0);
      rt = 1 << (f_base(1, r) - r);
      for (int n = 0; n < 2 * rt + 1; n++) strobe(m_dl, 8'd0, 8'd0, 8'd7);
    end

    // R10 / R11: late strobes with the periodic divider running at 2 Hz
    cfg(0, 0, 1, 2, 16'h0);
    for (int n = 0; n < 3; n++) strobe(m_dl, 8'd0, 8'd0, 8'd7);
    strobe(m_dl + 16'd256 * 5 + 16'd7, 8'd0, 8'd0, 8'd7);
    for (int n = 0; n < 7; n++) strobe(m_dl, 8'd0, 8'd0, 8'd7);
    strobe(m_dl + 16'd256, 8'd0, 8'd0, 8'd7);
    strobe(m_dl + 16'd257, 8'd0, 8'd0, 8'd7);
    // R10 with update enabled, lag across the counter wrap
    cfg(1, 0, 1, 2, 16'h0);
    strobe(m_dl + 16'd256 * 40 + 16'd100, 8'd0, 8'd0, 8'd9);
    strobe(m_dl + 16'h7000, 8'd0, 8'd0, 8'd10);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule